// File: doc/BRIEF.md
# Multiplexed GPIO Bank Controller

This block controls a bank of general-purpose I/O lines. Each line is either driven by the bank's own output logic or handed to one of four internal peripheral functions. Per-line attributes are held in a small register file: ownership, output enable, output data, pull-up, pull-down, open-drain drive, interrupt enable and Schmitt-trigger disable. Most of these attributes change through paired set and clear addresses, so software never needs a read-modify-write sequence to change one line.

The pad side of the block produces an output value, an output enable and the pull controls for each line. It also passes out the Schmitt-disable bits and the interrupt-enable vector. The raw pad level comes back through a two-flop synchronizer and is stored in a pin-level register. That register can be read whichever source owns the line.

The bus is a single-cycle register port. A write takes effect at the clock edge where `bus_wr_i` is high. A read presents its data on `bus_rdata_o` one edge after `bus_rd_i` is high, and that data holds until the next read.

Top module: `gpio_mux_bank`

## Requirements
- R1: After reset the bank state is as follows. Every line is owned by the bank. Output enable, output data, pull-down, open-drain and interrupt enable are all 0. Pull-up is enabled on every line. Both select registers and the Schmitt register are 0. `bus_rdata_o` is 0.
- R2: A write to a set address (0x00 ownership, 0x03 output enable, 0x06 output data, 0x09 pull-up, 0x0C pull-down, 0x0F open-drain, 0x12 interrupt enable) sets the attribute on each line whose data bit is 1. Lines whose data bit is 0 keep their attribute.
- R3: A write to a clear address (0x01, 0x04, 0x07, 0x0A, 0x0D, 0x10, 0x13, in the same attribute order as R2) clears the attribute on each line whose data bit is 1. Lines whose data bit is 0 keep their attribute.
- R4: On a line owned by the bank, the pad value follows output data and the pad enable follows output enable. Open-drain drive (R6) modifies both.
- R5: On a line the bank does not own, the pad is driven by peripheral function {sel_hi,sel_lo}: 00 selects A (index 0), 01 selects B, 10 selects C and 11 selects D. Each function supplies its own per-line value and enable.
- R6: On an open-drain line, `pad_out_o` is 0. `pad_oe_o` is high only when the selected source enables its output and drives 0.
- R7: Setting pull-down clears pull-up on the same lines, and setting pull-up clears pull-down. `pad_pu_o` and `pad_pd_o` are never both high on any line.
- R8: Address 0x18 returns the pad level sampled three edges before the read edge. This holds for every line regardless of ownership.
- R9: Status addresses return the current attribute state: 0x02 ownership, 0x05 output enable, 0x08 output data, 0x0B pull-up inverted (1 means no pull-up), 0x0E pull-down, 0x11 open-drain, 0x14 interrupt enable. Set addresses, clear addresses and unmapped addresses read as 0.
- R10: Addresses 0x15 (sel_lo), 0x16 (sel_hi) and 0x17 (Schmitt disable) are read/write registers. The Schmitt register drives `pad_st_off_o` directly.
- R11: `irq_en_o` presents the interrupt-enable state of every line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 5 | Register address |
| bus_wdata_i | input | 32 | Write data, one bit per line |
| bus_rdata_o | output | 32 | Read data, registered |
| per_out_i | input | 4x32 | Peripheral output values, index = function |
| per_oe_i | input | 4x32 | Peripheral output enables, index = function |
| pad_in_i | input | 32 | Raw pad levels |
| pad_out_o | output | 32 | Pad output value |
| pad_oe_o | output | 32 | Pad output enable |
| pad_pu_o | output | 32 | Pad pull-up enable |
| pad_pd_o | output | 32 | Pad pull-down enable |
| pad_st_off_o | output | 32 | Pad Schmitt-trigger disable |
| irq_en_o | output | 32 | Per-line interrupt enable |

## Verification
The hardest case to reach is a line that a peripheral owns, runs open-drain and selects function D. Reaching it needs a cleared ownership bit, both select bits set and an open-drain set, with the selected function driving 0 with its enable high. Each of those conditions comes from a separate write. The stimulus first programs select patterns that cover all four functions across the lines, together with a mixed open-drain mask. It then issues long runs of random writes and reads whose addresses cover every mapped register, while the peripheral and pad inputs change at random. In this way every combination of owner, select and drive mode occurs on some line.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned NUM_FUNCS = 4;
    localparam int unsigned SEL_W     = $clog2(NUM_FUNCS);

    localparam logic [ADDR_W-1:0] ADR_OWN_SET = 5'h00;
    localparam logic [ADDR_W-1:0] ADR_OWN_CLR = 5'h01;
    localparam logic [ADDR_W-1:0] ADR_OWN_STA = 5'h02;
    localparam logic [ADDR_W-1:0] ADR_OE_SET  = 5'h03;
    localparam logic [ADDR_W-1:0] ADR_OE_CLR  = 5'h04;
    localparam logic [ADDR_W-1:0] ADR_OE_STA  = 5'h05;
    localparam logic [ADDR_W-1:0] ADR_DO_SET  = 5'h06;
    localparam logic [ADDR_W-1:0] ADR_DO_CLR  = 5'h07;
    localparam logic [ADDR_W-1:0] ADR_DO_STA  = 5'h08;
    localparam logic [ADDR_W-1:0] ADR_PU_SET  = 5'h09;
    localparam logic [ADDR_W-1:0] ADR_PU_CLR  = 5'h0A;
    localparam logic [ADDR_W-1:0] ADR_PU_STA  = 5'h0B;
    localparam logic [ADDR_W-1:0] ADR_PD_SET  = 5'h0C;
    localparam logic [ADDR_W-1:0] ADR_PD_CLR  = 5'h0D;
    localparam logic [ADDR_W-1:0] ADR_PD_STA  = 5'h0E;
    localparam logic [ADDR_W-1:0] ADR_OD_SET  = 5'h0F;
    localparam logic [ADDR_W-1:0] ADR_OD_CLR  = 5'h10;
    localparam logic [ADDR_W-1:0] ADR_OD_STA  = 5'h11;
    localparam logic [ADDR_W-1:0] ADR_IE_SET  = 5'h12;
    localparam logic [ADDR_W-1:0] ADR_IE_CLR  = 5'h13;
    localparam logic [ADDR_W-1:0] ADR_IE_STA  = 5'h14;
    localparam logic [ADDR_W-1:0] ADR_SEL_LO  = 5'h15;
    localparam logic [ADDR_W-1:0] ADR_SEL_HI  = 5'h16;
    localparam logic [ADDR_W-1:0] ADR_ST_OFF  = 5'h17;
    localparam logic [ADDR_W-1:0] ADR_LEVEL   = 5'h18;
endpackage

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
    import gpio_mux_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [NUM_LINES-1:0] wdata_i,
    input  logic [NUM_LINES-1:0] level_i,
    output logic [NUM_LINES-1:0] own_o,
    output logic [NUM_LINES-1:0] oe_o,
    output logic [NUM_LINES-1:0] dout_o,
    output logic [NUM_LINES-1:0] pu_o,
    output logic [NUM_LINES-1:0] pd_o,
    output logic [NUM_LINES-1:0] od_o,
    output logic [NUM_LINES-1:0] ie_o,
    output logic [NUM_LINES-1:0] sel_lo_o,
    output logic [NUM_LINES-1:0] sel_hi_o,
    output logic [NUM_LINES-1:0] st_off_o,
    output logic [NUM_LINES-1:0] rdata_o
);
    typedef logic [NUM_LINES-1:0] vec_t;

    typedef struct packed {
        vec_t own;
        vec_t oe;
        vec_t dout;
        vec_t pu;
        vec_t pd;
        vec_t od;
        vec_t ie;
        vec_t sel_lo;
        vec_t sel_hi;
        vec_t st_off;
        vec_t rdata;
    } state_t;

    localparam vec_t ONES  = {NUM_LINES{1'b1}};
    localparam vec_t ZEROS = '0;
    localparam state_t RST_STATE = '{
        own: ONES, oe: ZEROS, dout: ZEROS, pu: ONES, pd: ZEROS, od: ZEROS,
        ie: ZEROS, sel_lo: ZEROS, sel_hi: ZEROS, st_off: ZEROS, rdata: ZEROS
    };

    state_t st_d, st_q;
    vec_t   rd_mux;

    always_comb begin
        unique case (addr_i)
            ADR_OWN_STA: rd_mux = st_q.own;
            ADR_OE_STA:  rd_mux = st_q.oe;
            ADR_DO_STA:  rd_mux = st_q.dout;
            ADR_PU_STA:  rd_mux = ~st_q.pu;
            ADR_PD_STA:  rd_mux = st_q.pd;
            ADR_OD_STA:  rd_mux = st_q.od;
            ADR_IE_STA:  rd_mux = st_q.ie;
            ADR_SEL_LO:  rd_mux = st_q.sel_lo;
            ADR_SEL_HI:  rd_mux = st_q.sel_hi;
            ADR_ST_OFF:  rd_mux = st_q.st_off;
            ADR_LEVEL:   rd_mux = level_i;
            default:     rd_mux = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            st_d.rdata = rd_mux;
        end
        if (wr_i) begin
            unique case (addr_i)
                ADR_OWN_SET: st_d.own  = st_q.own  | wdata_i;
                ADR_OWN_CLR: st_d.own  = st_q.own  & ~wdata_i;
                ADR_OE_SET:  st_d.oe   = st_q.oe   | wdata_i;
                ADR_OE_CLR:  st_d.oe   = st_q.oe   & ~wdata_i;
                ADR_DO_SET:  st_d.dout = st_q.dout | wdata_i;
                ADR_DO_CLR:  st_d.dout = st_q.dout & ~wdata_i;
                ADR_PU_SET: begin
                    st_d.pu = st_q.pu | wdata_i;
                    st_d.pd = st_q.pd & ~wdata_i;
                end
                ADR_PU_CLR:  st_d.pu   = st_q.pu   & ~wdata_i;
                ADR_PD_SET: begin
                    st_d.pd = st_q.pd | wdata_i;
                    st_d.pu = st_q.pu & ~wdata_i;
                end
                ADR_PD_CLR:  st_d.pd     = st_q.pd & ~wdata_i;
                ADR_OD_SET:  st_d.od     = st_q.od | wdata_i;
                ADR_OD_CLR:  st_d.od     = st_q.od & ~wdata_i;
                ADR_IE_SET:  st_d.ie     = st_q.ie | wdata_i;
                ADR_IE_CLR:  st_d.ie     = st_q.ie & ~wdata_i;
                ADR_SEL_LO:  st_d.sel_lo = wdata_i;
                ADR_SEL_HI:  st_d.sel_hi = wdata_i;
                ADR_ST_OFF:  st_d.st_off = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign own_o    = st_q.own;
    assign oe_o     = st_q.oe;
    assign dout_o   = st_q.dout;
    assign pu_o     = st_q.pu;
    assign pd_o     = st_q.pd;
    assign od_o     = st_q.od;
    assign ie_o     = st_q.ie;
    assign sel_lo_o = st_q.sel_lo;
    assign sel_hi_o = st_q.sel_hi;
    assign st_off_o = st_q.st_off;
    assign rdata_o  = st_q.rdata;
endmodule

// File: rtl/gpio_mux_route.sv
module gpio_mux_route
    import gpio_mux_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic [NUM_LINES-1:0]                own_i,
    input  logic [NUM_LINES-1:0]                oe_i,
    input  logic [NUM_LINES-1:0]                dout_i,
    input  logic [NUM_LINES-1:0]                od_i,
    input  logic [NUM_LINES-1:0]                sel_lo_i,
    input  logic [NUM_LINES-1:0]                sel_hi_i,
    input  logic [NUM_FUNCS-1:0][NUM_LINES-1:0] per_out_i,
    input  logic [NUM_FUNCS-1:0][NUM_LINES-1:0] per_oe_i,
    output logic [NUM_LINES-1:0]                pad_out_o,
    output logic [NUM_LINES-1:0]                pad_oe_o
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [SEL_W-1:0] sel;
        logic             src_val;
        logic             src_oe;

        assign sel = {sel_hi_i[i], sel_lo_i[i]};

        always_comb begin
            if (own_i[i]) begin
                src_val = dout_i[i];
                src_oe  = oe_i[i];
            end else begin
                src_val = per_out_i[sel][i];
                src_oe  = per_oe_i[sel][i];
            end
            if (od_i[i]) begin
                pad_out_o[i] = 1'b0;
                pad_oe_o[i]  = src_oe & ~src_val;
            end else begin
                pad_out_o[i] = src_val;
                pad_oe_o[i]  = src_oe;
            end
        end
    end
endmodule

// File: rtl/gpio_mux_sync.sv
module gpio_mux_sync #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned STAGES    = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_LINES-1:0] pad_i,
    output logic [NUM_LINES-1:0] level_o
);
    typedef struct packed {
        logic [STAGES-1:0][NUM_LINES-1:0] stg;
        logic [NUM_LINES-1:0]             lvl;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.stg[0] = pad_i;
        for (int s = 1; s < STAGES; s++) begin
            sy_d.stg[s] = sy_q.stg[s-1];
        end
        sy_d.lvl = sy_q.stg[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sy_q <= '0;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign level_o = sy_q.lvl;
endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
    import gpio_mux_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic                                bus_wr_i,
    input  logic                                bus_rd_i,
    input  logic [ADDR_W-1:0]                   bus_addr_i,
    input  logic [NUM_LINES-1:0]                bus_wdata_i,
    output logic [NUM_LINES-1:0]                bus_rdata_o,
    input  logic [NUM_FUNCS-1:0][NUM_LINES-1:0] per_out_i,
    input  logic [NUM_FUNCS-1:0][NUM_LINES-1:0] per_oe_i,
    input  logic [NUM_LINES-1:0]                pad_in_i,
    output logic [NUM_LINES-1:0]                pad_out_o,
    output logic [NUM_LINES-1:0]                pad_oe_o,
    output logic [NUM_LINES-1:0]                pad_pu_o,
    output logic [NUM_LINES-1:0]                pad_pd_o,
    output logic [NUM_LINES-1:0]                pad_st_off_o,
    output logic [NUM_LINES-1:0]                irq_en_o
);
    logic [NUM_LINES-1:0] own_w, oe_w, dout_w, od_w, sel_lo_w, sel_hi_w, level_w;

    gpio_mux_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pad_i   (pad_in_i),
        .level_o (level_w)
    );

    gpio_mux_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (bus_wr_i),
        .rd_i     (bus_rd_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .level_i  (level_w),
        .own_o    (own_w),
        .oe_o     (oe_w),
        .dout_o   (dout_w),
        .pu_o     (pad_pu_o),
        .pd_o     (pad_pd_o),
        .od_o     (od_w),
        .ie_o     (irq_en_o),
        .sel_lo_o (sel_lo_w),
        .sel_hi_o (sel_hi_w),
        .st_off_o (pad_st_off_o),
        .rdata_o  (bus_rdata_o)
    );

    gpio_mux_route #(.NUM_LINES(NUM_LINES)) u_route (
        .own_i     (own_w),
        .oe_i      (oe_w),
        .dout_i    (dout_w),
        .od_i      (od_w),
        .sel_lo_i  (sel_lo_w),
        .sel_hi_i  (sel_hi_w),
        .per_out_i (per_out_i),
        .per_oe_i  (per_oe_i),
        .pad_out_o (pad_out_o),
        .pad_oe_o  (pad_oe_o)
    );
endmodule

// File: rtl/gpio_mux_bank_chk.sv
module gpio_mux_bank_chk
    import gpio_mux_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 wr_i,
    input logic                 rd_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [NUM_LINES-1:0] wdata_i,
    input logic [NUM_LINES-1:0] rdata_i,
    input logic [NUM_LINES-1:0] oe_i,
    input logic [NUM_LINES-1:0] od_i,
    input logic [NUM_LINES-1:0] sel_lo_i,
    input logic [NUM_LINES-1:0] pad_out_i,
    input logic [NUM_LINES-1:0] pad_pu_i,
    input logic [NUM_LINES-1:0] pad_pd_i
);
    // R2
    oe_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == ADR_OE_SET) |=> ((oe_i & $past(wdata_i)) == $past(wdata_i)));

    // R3
    oe_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == ADR_OE_CLR) |=> ((oe_i & $past(wdata_i)) == '0));

    // R6
    od_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((od_i & pad_out_i) == '0));

    // R7
    pull_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pad_pu_i & pad_pd_i) == '0));

    // R9
    set_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == ADR_OWN_SET) |=> (rdata_i == '0));

    // R10
    sel_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == ADR_SEL_LO) |=> (sel_lo_i == $past(wdata_i)));
endmodule

bind gpio_mux_bank gpio_mux_bank_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_wr_i),
    .rd_i      (bus_rd_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_i   (bus_rdata_o),
    .oe_i      (oe_w),
    .od_i      (od_w),
    .sel_lo_i  (sel_lo_w),
    .pad_out_i (pad_out_o),
    .pad_pu_i  (pad_pu_o),
    .pad_pd_i  (pad_pd_o)
);

// File: tb/test_gpio_mux_bank.sv
module test_gpio_mux_bank;
    import gpio_mux_pkg::*;
    localparam int N = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                        rst_ni = 1'b0;
    logic                        wr = 1'b0, rd = 1'b0;
    logic [ADDR_W-1:0]           addr = '0;
    logic [N-1:0]                wdata = '0;
    logic [N-1:0]                rdata;
    logic [NUM_FUNCS-1:0][N-1:0] per_out = '0, per_oe = '0;
    logic [N-1:0]                pad_in = '0;
    logic [N-1:0]                pad_out, pad_oe, pad_pu, pad_pd, pad_st, irq_en;

    gpio_mux_bank i_gpio_mux_bank (
        .clk_i(clk), .rst_ni(rst_ni), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .per_out_i(per_out), .per_oe_i(per_oe), .pad_in_i(pad_in),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu),
        .pad_pd_o(pad_pd), .pad_st_off_o(pad_st), .irq_en_o(irq_en)
    );

    int n_chk = 0, n_err = 0;
    bit finished = 1'b0;

    // reference model state
    bit [N-1:0] m_own, m_oe, m_do, m_pu, m_pd, m_od, m_ie, m_slo, m_shi, m_st, m_rd, m_lvl;
    bit [N-1:0] hist[$];

    function automatic bit [N-1:0] m_read(input logic [ADDR_W-1:0] a);
        case (a)
            5'h02: return m_own;
            5'h05: return m_oe;
            5'h08: return m_do;
            5'h0B: return ~m_pu;
            5'h0E: return m_pd;
            5'h11: return m_od;
            5'h14: return m_ie;
            5'h15: return m_slo;
            5'h16: return m_shi;
            5'h17: return m_st;
            5'h18: return m_lvl;
            default: return '0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            m_own = '1; m_oe = '0; m_do = '0; m_pu = '1; m_pd = '0; m_od = '0;
            m_ie = '0; m_slo = '0; m_shi = '0; m_st = '0; m_rd = '0; m_lvl = '0;
            hist.delete();
        end else begin
            if (rd) m_rd = m_read(addr);
            if (wr) begin
                case (addr)
                    5'h00: m_own |= wdata;  5'h01: m_own &= ~wdata;
                    5'h03: m_oe  |= wdata;  5'h04: m_oe  &= ~wdata;
                    5'h06: m_do  |= wdata;  5'h07: m_do  &= ~wdata;
                    5'h09: begin m_pu |= wdata; m_pd &= ~wdata; end
                    5'h0A: m_pu &= ~wdata;
                    5'h0C: begin m_pd |= wdata; m_pu &= ~wdata; end
                    5'h0D: m_pd &= ~wdata;
                    5'h0F: m_od  |= wdata;  5'h10: m_od  &= ~wdata;
                    5'h12: m_ie  |= wdata;  5'h13: m_ie  &= ~wdata;
                    5'h15: m_slo = wdata;   5'h16: m_shi = wdata;
                    5'h17: m_st  = wdata;
                    default: ;
                endcase
            end
            hist.push_back(pad_in);
            if (hist.size() > 3) void'(hist.pop_front());
            m_lvl = (hist.size() == 3) ? hist[0] : '0;
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_ni && !finished) begin
            bit [N-1:0] e_out, e_oe;
            for (int i = 0; i < N; i++) begin
                bit v, o;
                int f;
                f = {m_shi[i], m_slo[i]};
                v = m_own[i] ? m_do[i] : per_out[f][i];
                o = m_own[i] ? m_oe[i] : per_oe[f][i];
                e_out[i] = m_od[i] ? 1'b0 : v;
                e_oe[i]  = m_od[i] ? (o & ~v) : o;
            end
            chk("R4 R5 R6 pad_out", pad_out, e_out);
            chk("R4 R5 R6 pad_oe", pad_oe, e_oe);
            chk("R7 pad_pu", pad_pu, m_pu);
            chk("R7 pad_pd", pad_pd, m_pd);
            chk("R10 pad_st_off", pad_st, m_st);
            chk("R11 irq_en", irq_en, m_ie);
            chk("R1 R2 R3 R8 R9 R10 rdata", rdata, m_rd);
        end
    end

    task automatic op(input bit w, input bit r, input logic [ADDR_W-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        #1;
        wr = w; rd = r; addr = a; wdata = d;
    endtask

    task automatic rd_all();
        for (int a = 0; a < 26; a++) op(1'b0, 1'b1, 5'(a), '0);
    endtask

    initial begin
        #1_500_000;
        n_err++;
        $display("FAIL watchdog expired");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_ni = 1'b1;
        // R1: reset values through every read address
        rd_all();
        // R5: cover all four functions across lines, peripherals own half the lines
        per_out = {32'hFF00FF00, 32'hF0F0F0F0, 32'hCCCCCCCC, 32'hAAAAAAAA};
        per_oe  = {32'h0F0F0F0F, 32'hFFFF0000, 32'h33333333, 32'h5555AAAA};
        op(1'b1, 1'b0, ADR_SEL_LO, 32'hAAAAAAAA);
        op(1'b1, 1'b0, ADR_SEL_HI, 32'hCCCCCCCC);
        op(1'b1, 1'b0, ADR_OWN_CLR, 32'h0000FFFF);
        // R2 / R3 on bank-owned lines
        op(1'b1, 1'b0, ADR_OE_SET, 32'hFFFF00F0);
        op(1'b1, 1'b0, ADR_DO_SET, 32'h12345678);
        op(1'b1, 1'b0, ADR_DO_CLR, 32'h00000070);
        // R6 open-drain over mixed owners
        op(1'b1, 1'b0, ADR_OD_SET, 32'h0F0FF0F0);
        // R7 pull exclusivity both directions
        op(1'b1, 1'b0, ADR_PD_SET, 32'h000000FF);
        op(1'b1, 1'b0, ADR_PU_SET, 32'h0000000F);
        op(1'b1, 1'b0, ADR_IE_SET, 32'h80000001);
        op(1'b1, 1'b0, ADR_ST_OFF, 32'h00FF00FF);
        // R8 pin level regardless of owner
        pad_in = 32'hDEADBEEF;
        repeat (4) op(1'b0, 1'b1, ADR_LEVEL, '0);
        rd_all();
        // long random phase
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            #1;
            wr = ($urandom_range(0, 2) != 0);
            rd = $urandom_range(0, 1);
            addr = 5'($urandom_range(0, 26));
            wdata = $urandom;
            if ($urandom_range(0, 3) == 0) pad_in = $urandom;
            if ($urandom_range(0, 7) == 0) begin
                for (int f = 0; f < NUM_FUNCS; f++) begin
                    per_out[f] = $urandom;
                    per_oe[f]  = $urandom;
                end
            end
        end
        op(1'b0, 1'b0, '0, '0);
        rd_all();
        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule